// File: doc/BRIEF.md
# Strobed Code Latch with One-Hot Select Decoder

This block keeps a 4-bit select code in a register that is open while a strobe is high and closed once it drops, and it decodes the stored code into a 16-line one-hot select bus. An inhibit input forces every select line to its inactive level. It does not change the stored code, so the same select line comes back when inhibit is released. A build-time parameter fixes the polarity of the select bus. With active-high polarity the chosen line is 1 and the others are 0. With active-low polarity the chosen line is 0 and the others are 1.

The model is synchronous. Strobe and data are sampled on the rising edge of a system clock, and an active-low asynchronous reset clears the stored code. The decode and inhibit paths that follow the register are combinational, so inhibit acts on the select bus in the same cycle it is applied. Typical uses are address decoding, chip-select generation and driving one of sixteen control targets from a code that is loaded once and then held.

Top module: `strobe_latch_decoder`

## Requirements
- R1: When reset is asserted, the stored code is set to 0. With inhibit low after reset, select line 0 is active.
- R2: On each rising clock edge where strobe is sampled as 1, the stored code takes the value on the data inputs. The stored code is therefore transparent while strobe is high.
- R3: On a rising clock edge where strobe is sampled as 0, the stored code does not change. Data changes while strobe is low have no effect on the select bus. The value captured in the last strobe-high cycle before strobe falls is the one kept.
- R4: The data inputs carry the select code with bit 0 as the least significant bit and bit 3 as the most significant bit. A stored code n activates select bit n, for n from 0 to 15.
- R5: While inhibit is 0, exactly one select line is at its active level.
- R6: With ACTIVE_LOW = 0, the selected line is 1 and all other lines are 0.
- R7: With ACTIVE_LOW = 1, the selected line is 0 and all other lines are 1.
- R8: While inhibit is 1, every select line is at its inactive level (all 0 when ACTIVE_LOW = 0, all 1 when ACTIVE_LOW = 1), whatever the data and strobe inputs are. This takes effect in the same cycle, without waiting for a clock edge.
- R9: Inhibit does not affect the stored code. Capturing continues while inhibit is 1, and on release the select bus shows the code stored last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; strobe and data are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the stored code |
| data_i | input | CODE_W (4) | Select code, bit 0 least significant |
| strobe_i | input | 1 | Capture enable; 1 = transparent, 0 = hold |
| inhibit_i | input | 1 | Forces all select lines inactive; 1 = blank |
| sel_o | output | 2**CODE_W (16) | One-hot select bus, polarity set by ACTIVE_LOW |

## Verification
The bound checker watches the register behaviour on every cycle. It confirms that a strobe-high edge loads the data, that a strobe-low edge leaves the stored code alone, and that reset leaves the code at 0. On the select bus it checks that the active line matches the stored index, that exactly one line is active, and that inhibit blanks the bus. The bench's scenarios are needed for the full code sweep in both polarities. They also cover a data change in the same cycle that strobe falls, and an inhibit window in which a new code is loaded and must appear once inhibit is released.

// File: rtl/strobe_latch_decoder_pkg.sv
package strobe_latch_decoder_pkg;

  // Apply the output polarity to an "asserted" flag.
  function automatic logic pol_drive(input bit active_low, input logic asserted);
    return active_low ? ~asserted : asserted;
  endfunction

  // Inactive level of one select line for a given polarity.
  function automatic logic idle_level(input bit active_low);
    return active_low ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/sld_code_reg.sv
module sld_code_reg #(
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
    end else if (capture_i) begin
      code_q <= data_i;
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/sld_onehot_dec.sv
module sld_onehot_dec #(
  parameter int CODE_W = 4,
  localparam int OUT_W = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [OUT_W-1:0]  hit_o
);

  for (genvar gi = 0; gi < OUT_W; gi++) begin : g_line
    assign hit_o[gi] = (code_i == CODE_W'(gi));
  end

endmodule

// File: rtl/sld_out_stage.sv
module sld_out_stage
  import strobe_latch_decoder_pkg::*;
#(
  parameter int OUT_W      = 16,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic [OUT_W-1:0] hit_i,
  input  logic             blank_i,
  output logic [OUT_W-1:0] sel_o
);

  logic [OUT_W-1:0] gated;

  assign gated = hit_i & {OUT_W{~blank_i}};

  if (ACTIVE_LOW) begin : g_low
    for (genvar gi = 0; gi < OUT_W; gi++) begin : g_bit
      assign sel_o[gi] = pol_drive(1'b1, gated[gi]);
    end
  end else begin : g_high
    for (genvar gi = 0; gi < OUT_W; gi++) begin : g_bit
      assign sel_o[gi] = pol_drive(1'b0, gated[gi]);
    end
  end

endmodule

// File: rtl/strobe_latch_decoder.sv
module strobe_latch_decoder #(
  parameter int CODE_W     = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int OUT_W     = 1 << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] data_i,
  input  logic              strobe_i,
  input  logic              inhibit_i,
  output logic [OUT_W-1:0]  sel_o
);

  // Named internal events, visible to the bound checker.
  logic              capture_en;
  logic [CODE_W-1:0] latched_code;
  logic [OUT_W-1:0]  dec_onehot;
  logic              blank_en;

  assign capture_en = strobe_i;
  assign blank_en   = inhibit_i;

  sld_code_reg #(.CODE_W(CODE_W)) u_code_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture_en),
    .data_i    (data_i),
    .code_o    (latched_code)
  );

  sld_onehot_dec #(.CODE_W(CODE_W)) u_dec (
    .code_i (latched_code),
    .hit_o  (dec_onehot)
  );

  sld_out_stage #(.OUT_W(OUT_W), .ACTIVE_LOW(ACTIVE_LOW)) u_out (
    .hit_i   (dec_onehot),
    .blank_i (blank_en),
    .sel_o   (sel_o)
  );

endmodule

// File: rtl/strobe_latch_decoder_chk.sv
module strobe_latch_decoder_chk
  import strobe_latch_decoder_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int OUT_W     = 1 << CODE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] data_i,
  input logic              capture_en,
  input logic              blank_en,
  input logic [CODE_W-1:0] latched_code,
  input logic [OUT_W-1:0]  sel_o
);

  logic [OUT_W-1:0] active_vec;
  assign active_vec = ACTIVE_LOW ? ~sel_o : sel_o;

  // R1: first edge after reset release still shows code 0
  p_reset_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> latched_code == '0);

  // R2: strobe high at an edge loads the sampled data
  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(capture_en)) |-> latched_code == $past(data_i));

  // R3: strobe low at an edge keeps the stored code
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(capture_en)) |-> $stable(latched_code));

  // R4: the active line is the one indexed by the stored code
  p_index_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_en |-> active_vec[latched_code] == 1'b1);

  // R5: exactly one active line when not blanked
  p_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_en |-> $countones(active_vec) == 1);

  // R8: inhibit drives every line to the idle level
  p_blank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_en |-> sel_o == {OUT_W{idle_level(ACTIVE_LOW)}});

endmodule

bind strobe_latch_decoder strobe_latch_decoder_chk #(
  .CODE_W(CODE_W), .ACTIVE_LOW(ACTIVE_LOW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .data_i       (data_i),
  .capture_en   (capture_en),
  .blank_en     (blank_en),
  .latched_code (latched_code),
  .sel_o        (sel_o)
);

// File: tb/strobe_latch_decoder_bench.sv
module strobe_latch_decoder_bench;

  localparam int CW = 4;
  localparam int OW = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] data = '0;
  logic          strobe = 1'b0;
  logic          inhibit = 1'b0;
  logic [OW-1:0] sel_hi;
  logic [OW-1:0] sel_lo;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  strobe_latch_decoder #(.CODE_W(CW), .ACTIVE_LOW(1'b0)) u_strobe_latch_decoder (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .strobe_i(strobe),
    .inhibit_i(inhibit), .sel_o(sel_hi));

  strobe_latch_decoder #(.CODE_W(CW), .ACTIVE_LOW(1'b1)) u_strobe_latch_decoder_n (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .strobe_i(strobe),
    .inhibit_i(inhibit), .sel_o(sel_lo));

  function automatic logic [OW-1:0] want_hi(input int code, input bit blank);
    logic [OW-1:0] v;
    v = '0;
    if (!blank) v[code] = 1'b1;
    return v;
  endfunction

  task automatic check_both(input string req, input int code, input bit blank);
    logic [OW-1:0] eh;
    logic [OW-1:0] el;
    eh = want_hi(code, blank);
    el = blank ? {OW{1'b1}} : ~eh;
    checks++;
    if (sel_hi !== eh) begin
      failures++;
      $display("FAIL %s active-high: actual=%h expected=%h", req, sel_hi, eh);
    end
    checks++;
    if (sel_lo !== el) begin
      failures++;
      $display("FAIL %s active-low: actual=%h expected=%h", req, sel_lo, el);
    end
  endtask

  // one clock edge, then settle to the middle of the high phase
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; strobe = 1'b0; inhibit = 1'b0; data = 4'hA;
    repeat (2) tick();
    check_both("R1 reset code", 0, 1'b0);
    rst_n = 1'b1;
    tick();
    check_both("R1 after release", 0, 1'b0);
  endtask

  task automatic t_sweep();
    for (int c = 0; c < OW; c++) begin
      data = CW'(c); strobe = 1'b1;
      tick();
      check_both("R2 R4 R5 R6 R7 sweep", c, 1'b0);
    end
    // descending order too, so a stuck bit cannot hide behind counting up
    for (int c = OW - 1; c >= 0; c -= 5) begin
      data = CW'(c);
      tick();
      check_both("R4 descending", c, 1'b0);
    end
    strobe = 1'b0;
  endtask

  task automatic t_hold();
    strobe = 1'b1; data = 4'h9;
    tick();
    strobe = 1'b0; data = 4'h3;
    tick();
    check_both("R3 data change ignored", 9, 1'b0);
    data = 4'hF;
    repeat (3) tick();
    check_both("R3 hold over several edges", 9, 1'b0);
    // strobe falls in the same cycle that data changes: the old value is kept
    strobe = 1'b1; data = 4'h5;
    tick();
    strobe = 1'b0; data = 4'hC;
    tick();
    check_both("R3 last value before fall", 5, 1'b0);
  endtask

  task automatic t_inhibit();
    strobe = 1'b1; data = 4'h7;
    tick();
    strobe = 1'b0;
    tick();
    inhibit = 1'b1;
    #1;
    check_both("R8 immediate blank", 0, 1'b1);
    strobe = 1'b1; data = 4'hB;
    tick();
    check_both("R8 blank with strobe high", 0, 1'b1);
    strobe = 1'b0; data = 4'h2;
    tick();
    check_both("R8 blank with data change", 0, 1'b1);
    inhibit = 1'b0;
    #1;
    check_both("R9 code loaded under inhibit", 11, 1'b0);
    inhibit = 1'b1;
    tick();
    inhibit = 1'b0;
    #1;
    check_both("R9 code kept across inhibit", 11, 1'b0);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sweep();
    t_hold();
    t_inhibit();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule